// File: doc/BRIEF.md
# Frequency-Compare PLL Lock Detector

This block decides whether a phase-locked loop has settled. It measures the loop's feedback clock against its reference clock by counting edges. It does not compare their phase. Two programmable dividers are built in. One divides the source clock by `ref_ratio + 1` to form the reference. The other divides the VCO clock by `fb_ratio + 1` to form the feedback. Both divided clocks are kept as one-cycle enables in their own clock domains, so no gated clocks are created.

A free-running feedback-tick counter runs in the VCO domain. It is carried into the source domain in Gray code. Every `WIN_LEN` reference periods, the number of feedback ticks seen in that window is compared with `WIN_LEN`, allowing a band of ±`TOL`. Lock is declared after `LOCK_WINS` good windows in a row. It is dropped after `UNLOCK_WINS` bad windows in a row, or at once when software rewrites either divider ratio. Every change of the lock status, in either direction, sets a sticky change flag. That flag drives an interrupt line only while the enable is set. All pins are plain control and status. The block carries no data stream, so no valid/ready handshake applies.

Because the window is counted in reference periods, the detector answers more slowly when the reference frequency is lower.

Top module: `pll_lock_detect`

## Requirements
- R1: After reset, `lock`, `chg_flag` and `lock_irq` are all 0.
- R2: A reference period lasts `ref_ratio+1` source-clock cycles and a feedback tick occurs once per `fb_ratio+1` VCO cycles. A measurement window lasts `WIN_LEN` reference periods and begins at the last ratio write.
- R3: `lock` rises only at the end of the `LOCK_WINS`-th consecutive in-band window (2 by default). It is still 0 after the first in-band window.
- R4: `lock` falls at the end of an out-of-band window, whether the feedback is too slow or too fast.
- R5: A write to either ratio clears `lock` on the next clock and restarts the window, so relocking again takes `LOCK_WINS` full windows.
- R6: Every change of `lock`, whether rising, falling or caused by a write, sets `chg_flag`. The flag then holds until it is cleared.
- R7: A one-cycle pulse on `chg_clr` clears `chg_flag` on the next clock, provided `lock` does not change in that same cycle.
- R8: `lock_irq` follows `chg_flag` while `irq_en` is 1 and stays 0 while `irq_en` is 0. The flag is still recorded while the enable is 0.
- R9: A window is in band when its tick count n satisfies `WIN_LEN-TOL <= n <= WIN_LEN+TOL`. With the bench build, counts 14 and 18 lock, and counts 13 and 19 do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source clock for the reference divider and all decision logic |
| src_rst_n | input | 1 | Asynchronous active-low reset, source domain |
| vco_clk | input | 1 | VCO output clock |
| vco_rst_n | input | 1 | Asynchronous active-low reset, VCO domain |
| ref_ratio_wr | input | 1 | Write strobe for the reference ratio |
| ref_ratio | input | REF_W (4) | Reference divide value minus one |
| fb_ratio_wr | input | 1 | Write strobe for the feedback ratio |
| fb_ratio | input | FB_W (6) | Feedback divide value minus one |
| irq_en | input | 1 | Interrupt enable for lock changes |
| chg_clr | input | 1 | Write-one pulse that clears the change flag |
| lock | output | 1 | Read-only lock status |
| chg_flag | output | 1 | Sticky lock-change flag |
| lock_irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `WIN_LEN=16`, `TOL=2` and `CNT_W=8`. A window then lasts only 16 to 64 source cycles, which makes a near-exhaustive sweep affordable: reference ratios 0, 1 and 3, feedback ratios 0, 1, 3 and 7, and seven VCO frequencies per pair. The VCO period is computed so that each window holds an exact whole number of feedback ticks. That brings both edges of the tolerance band within reach (14 and 18 in band, 13 and 19 out), as well as the far cases of 8 and 32 ticks.

// File: rtl/pll_lkd_pkg.sv
`timescale 1ns/1fs
package pll_lkd_pkg;
  localparam int REF_RATIO_W = 4;
  localparam int FB_RATIO_W  = 6;

  // outcome of one measurement window
  typedef enum logic [1:0] {
    CMP_SLOW = 2'd0,
    CMP_IN   = 2'd1,
    CMP_FAST = 2'd2
  } cmp_t;
endpackage

// File: rtl/pll_lkd_prescaler.sv
`timescale 1ns/1fs
// Divide-by-(ratio+1) enable generator; tick is high one cycle in ratio+1.
module pll_lkd_prescaler #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] ratio,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  // >= keeps the divider safe when ratio drops below the running count
  assign tick = (cnt_q >= ratio);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (restart || tick)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pll_lkd_fb_gray.sv
`timescale 1ns/1fs
// Free-running feedback tick counter, published as a registered Gray code.
module pll_lkd_fb_gray #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] gray
);
  logic [W-1:0] bin_q;
  logic [W-1:0] bin_nxt;

  assign bin_nxt = bin_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q <= '0;
      gray  <= '0;
    end else if (tick) begin
      bin_q <= bin_nxt;
      gray  <= bin_nxt ^ (bin_nxt >> 1);
    end
  end
endmodule

// File: rtl/pll_lkd_gray_sync.sv
`timescale 1ns/1fs
// Multi-stage synchronizer for a Gray-coded count, followed by Gray-to-binary.
module pll_lkd_gray_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= gray_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++)
      bin_out[i] = ^(stg[STAGES-1] >> i);
  end
endmodule

// File: rtl/pll_lkd_judge.sv
`timescale 1ns/1fs
// Reference-domain window timer, tolerance compare, lock hysteresis and flag.
module pll_lkd_judge
  import pll_lkd_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int WIN_LEN     = 64,
  parameter int TOL         = 2,
  parameter int LOCK_WINS   = 2,
  parameter int UNLOCK_WINS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             ref_tick,
  input  logic [CNT_W-1:0] fb_cnt,
  input  logic             irq_en,
  input  logic             chg_clr,
  output logic             lock,
  output logic             chg_flag,
  output logic             lock_irq,
  output logic             win_done,
  output logic             in_band
);
  localparam int WCNT_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam int GOOD_W = $clog2(LOCK_WINS + 1);
  localparam int BAD_W  = $clog2(UNLOCK_WINS + 1);
  localparam logic [CNT_W-1:0]  BAND_LO = CNT_W'(WIN_LEN - TOL);
  localparam logic [CNT_W-1:0]  BAND_HI = CNT_W'(WIN_LEN + TOL);
  localparam logic [WCNT_W-1:0] WIN_LAST = WCNT_W'(WIN_LEN - 1);

  logic [WCNT_W-1:0] wcnt_q;
  logic [CNT_W-1:0]  base_q;
  logic [CNT_W-1:0]  delta;
  logic [GOOD_W-1:0] good_q, good_d;
  logic [BAD_W-1:0]  bad_q, bad_d;
  logic              lock_d, flag_d;
  logic              good_hit, bad_hit;
  cmp_t              verdict;

  // window boundary and tick count since the previous boundary (modular)
  assign win_done = ref_tick && (wcnt_q == WIN_LAST) && !restart;
  assign delta    = fb_cnt - base_q;

  always_comb begin
    if (delta < BAND_LO)      verdict = CMP_SLOW;
    else if (delta > BAND_HI) verdict = CMP_FAST;
    else                      verdict = CMP_IN;
  end
  assign in_band = (verdict == CMP_IN);

  assign good_hit = (int'(good_q) + 1) >= LOCK_WINS;
  assign bad_hit  = (int'(bad_q) + 1) >= UNLOCK_WINS;

  always_comb begin
    lock_d = lock;
    good_d = good_q;
    bad_d  = bad_q;
    if (restart) begin
      lock_d = 1'b0;
      good_d = '0;
      bad_d  = '0;
    end else if (win_done) begin
      if (in_band) begin
        bad_d = '0;
        if (good_hit) begin
          lock_d = 1'b1;
          good_d = GOOD_W'(LOCK_WINS);
        end else begin
          good_d = good_q + 1'b1;
        end
      end else begin
        good_d = '0;
        if (bad_hit) begin
          lock_d = 1'b0;
          bad_d  = BAD_W'(UNLOCK_WINS);
        end else begin
          bad_d = bad_q + 1'b1;
        end
      end
    end
  end

  // a status change outranks a clear in the same cycle
  always_comb begin
    if (lock_d != lock) flag_d = 1'b1;
    else if (chg_clr)   flag_d = 1'b0;
    else                flag_d = chg_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      base_q <= '0;
    end else if (restart) begin
      wcnt_q <= '0;
      base_q <= fb_cnt;
    end else if (ref_tick) begin
      if (wcnt_q == WIN_LAST) begin
        wcnt_q <= '0;
        base_q <= fb_cnt;
      end else begin
        wcnt_q <= wcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock     <= 1'b0;
      chg_flag <= 1'b0;
      good_q   <= '0;
      bad_q    <= '0;
    end else begin
      lock     <= lock_d;
      chg_flag <= flag_d;
      good_q   <= good_d;
      bad_q    <= bad_d;
    end
  end

  assign lock_irq = chg_flag & irq_en;
endmodule

// File: rtl/pll_lock_detect.sv
`timescale 1ns/1fs
module pll_lock_detect
  import pll_lkd_pkg::*;
#(
  parameter int REF_W         = REF_RATIO_W,
  parameter int FB_W          = FB_RATIO_W,
  parameter int CNT_W         = 10,
  parameter int WIN_LEN       = 64,
  parameter int TOL           = 2,
  parameter int LOCK_WINS     = 2,
  parameter int UNLOCK_WINS   = 1,
  parameter int SYNC_STAGES   = 2,
  parameter int REF_RATIO_RST = 0,
  parameter int FB_RATIO_RST  = 31
) (
  input  logic            src_clk,
  input  logic            src_rst_n,
  input  logic            vco_clk,
  input  logic            vco_rst_n,
  input  logic            ref_ratio_wr,
  input  logic [REF_W-1:0] ref_ratio,
  input  logic            fb_ratio_wr,
  input  logic [FB_W-1:0] fb_ratio,
  input  logic            irq_en,
  input  logic            chg_clr,
  output logic            lock,
  output logic            chg_flag,
  output logic            lock_irq
);
  logic [REF_W-1:0] ref_q;
  logic [FB_W-1:0]  fb_q;
  logic             cfg_wr;
  logic             ref_tick;
  logic             fb_tick;
  logic [CNT_W-1:0] fb_gray;
  logic [CNT_W-1:0] fb_cnt;
  logic             win_done;
  logic             in_band;

  assign cfg_wr = ref_ratio_wr | fb_ratio_wr;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      ref_q <= REF_W'(REF_RATIO_RST);
      fb_q  <= FB_W'(FB_RATIO_RST);
    end else begin
      if (ref_ratio_wr) ref_q <= ref_ratio;
      if (fb_ratio_wr)  fb_q  <= fb_ratio;
    end
  end

  pll_lkd_prescaler #(.W(REF_W)) u_ref_div (
    .clk     (src_clk),
    .rst_n   (src_rst_n),
    .restart (cfg_wr),
    .ratio   (ref_q),
    .tick    (ref_tick)
  );

  // fb_q is quasi-static: it only changes at a write, which restarts the window
  pll_lkd_prescaler #(.W(FB_W)) u_fb_div (
    .clk     (vco_clk),
    .rst_n   (vco_rst_n),
    .restart (1'b0),
    .ratio   (fb_q),
    .tick    (fb_tick)
  );

  pll_lkd_fb_gray #(.W(CNT_W)) u_fb_cnt (
    .clk   (vco_clk),
    .rst_n (vco_rst_n),
    .tick  (fb_tick),
    .gray  (fb_gray)
  );

  pll_lkd_gray_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_fb_sync (
    .clk     (src_clk),
    .rst_n   (src_rst_n),
    .gray_in (fb_gray),
    .bin_out (fb_cnt)
  );

  pll_lkd_judge #(
    .CNT_W       (CNT_W),
    .WIN_LEN     (WIN_LEN),
    .TOL         (TOL),
    .LOCK_WINS   (LOCK_WINS),
    .UNLOCK_WINS (UNLOCK_WINS)
  ) u_judge (
    .clk      (src_clk),
    .rst_n    (src_rst_n),
    .restart  (cfg_wr),
    .ref_tick (ref_tick),
    .fb_cnt   (fb_cnt),
    .irq_en   (irq_en),
    .chg_clr  (chg_clr),
    .lock     (lock),
    .chg_flag (chg_flag),
    .lock_irq (lock_irq),
    .win_done (win_done),
    .in_band  (in_band)
  );
endmodule

// File: rtl/pll_lock_detect_chk.sv
`timescale 1ns/1fs
module pll_lock_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_wr,
  input logic win_done,
  input logic in_band,
  input logic lock,
  input logic chg_flag,
  input logic lock_irq,
  input logic irq_en,
  input logic chg_clr
);
  // R5
  cfg_wr_drops_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !lock);

  // R3
  lock_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(win_done && in_band));

  // R4
  lock_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> $past(cfg_wr || (win_done && !in_band)));

  // R6
  change_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock != $past(lock)) |-> chg_flag);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flag && !chg_clr) |=> chg_flag);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_clr && !win_done && !cfg_wr) |=> !chg_flag);

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !lock_irq);
endmodule

bind pll_lock_detect pll_lock_detect_chk u_chk (
  .clk      (src_clk),
  .rst_n    (src_rst_n),
  .cfg_wr   (cfg_wr),
  .win_done (win_done),
  .in_band  (in_band),
  .lock     (lock),
  .chg_flag (chg_flag),
  .lock_irq (lock_irq),
  .irq_en   (irq_en),
  .chg_clr  (chg_clr)
);

// File: tb/pll_lock_detect_tb.sv
`timescale 1ns/1fs
module pll_lock_detect_tb;
  localparam int WIN = 16;
  localparam int TOL = 2;

  logic       src_clk = 1'b0;
  logic       vco_clk = 1'b0;
  logic       src_rst_n = 1'b0;
  logic       vco_rst_n = 1'b0;
  logic       ref_ratio_wr = 1'b0;
  logic [3:0] ref_ratio = '0;
  logic       fb_ratio_wr = 1'b0;
  logic [5:0] fb_ratio = '0;
  logic       irq_en = 1'b1;
  logic       chg_clr = 1'b0;
  logic       lock, chg_flag, lock_irq;

  realtime vco_half = 5.0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  pll_lock_detect #(.CNT_W(8), .WIN_LEN(WIN), .TOL(TOL)) u_dut (
    .src_clk      (src_clk),
    .src_rst_n    (src_rst_n),
    .vco_clk      (vco_clk),
    .vco_rst_n    (vco_rst_n),
    .ref_ratio_wr (ref_ratio_wr),
    .ref_ratio    (ref_ratio),
    .fb_ratio_wr  (fb_ratio_wr),
    .fb_ratio     (fb_ratio),
    .irq_en       (irq_en),
    .chg_clr      (chg_clr),
    .lock         (lock),
    .chg_flag     (chg_flag),
    .lock_irq     (lock_irq)
  );

  always #5 src_clk = ~src_clk;

  initial begin
    #3.217;
    forever #(vco_half) vco_clk = ~vco_clk;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // VCO half period that puts exactly cnt feedback ticks in one window
  function automatic realtime half_for(input int r, input int s, input int cnt);
    return (10.0 * (r + 1) * WIN) / (2.0 * cnt * (s + 1));
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(negedge src_clk);
  endtask

  // feedback ratio first, let the divider settle, then the reference write opens the window
  task automatic program_ratios(input int r, input int s);
    @(negedge src_clk);
    fb_ratio = 6'(s);
    fb_ratio_wr = 1'b1;
    @(negedge src_clk);
    fb_ratio_wr = 1'b0;
    chk("R5 lock after ratio write", int'(lock), 0);
    cycles(20);
    ref_ratio = 4'(r);
    ref_ratio_wr = 1'b1;
    @(negedge src_clk);
    ref_ratio_wr = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge src_clk);
    chg_clr = 1'b1;
    @(negedge src_clk);
    chg_clr = 1'b0;
  endtask

  initial begin
    cycles(4);
    src_rst_n = 1'b1;
    vco_rst_n = 1'b1;
    @(negedge src_clk);
    // R1
    chk("R1 lock", int'(lock), 0);
    chk("R1 flag", int'(chg_flag), 0);
    chk("R1 irq", int'(lock_irq), 0);

    // R3: first good window is not enough, the second one locks
    vco_half = half_for(0, 1, 16);
    program_ratios(0, 1);
    cycles(24);
    chk("R3 after one window", int'(lock), 0);
    cycles(16);
    chk("R3 after two windows", int'(lock), 1);
    chk("R6 flag on rise", int'(chg_flag), 1);
    chk("R8 irq enabled", int'(lock_irq), 1);

    // R7
    pulse_clr();
    chk("R7 flag cleared", int'(chg_flag), 0);
    chk("R8 irq follows flag", int'(lock_irq), 0);

    // R4 too slow, with interrupt masked (R8)
    irq_en = 1'b0;
    vco_half = half_for(0, 1, 8);
    cycles(56);
    chk("R4 unlock slow", int'(lock), 0);
    chk("R6 flag on fall", int'(chg_flag), 1);
    chk("R8 irq masked", int'(lock_irq), 0);
    irq_en = 1'b1;
    #1;
    chk("R8 irq unmasked", int'(lock_irq), 1);
    pulse_clr();

    // relock, then R4 too fast
    vco_half = half_for(0, 1, 16);
    cycles(80);
    chk("R3 relock", int'(lock), 1);
    vco_half = half_for(0, 1, 32);
    cycles(56);
    chk("R4 unlock fast", int'(lock), 0);

    // R5: write while locked clears at once and restarts the window
    vco_half = half_for(0, 1, 16);
    cycles(80);
    chk("R3 relock again", int'(lock), 1);
    pulse_clr();
    @(negedge src_clk);
    ref_ratio = 4'd0;
    ref_ratio_wr = 1'b1;
    @(negedge src_clk);
    ref_ratio_wr = 1'b0;
    chk("R5 write clears lock", int'(lock), 0);
    chk("R6 flag on write", int'(chg_flag), 1);
    cycles(24);
    chk("R5 window restarted", int'(lock), 0);
    cycles(16);
    chk("R5 relock after restart", int'(lock), 1);

    // R2 and R9 sweep over ratios and feedback counts
    begin
      int rs[3]   = '{0, 1, 3};
      int ss[4]   = '{0, 1, 3, 7};
      int cnts[7] = '{16, 14, 18, 13, 19, 8, 32};
      for (int ri = 0; ri < 3; ri++) begin
        for (int si = 0; si < 4; si++) begin
          for (int ci = 0; ci < 7; ci++) begin
            int wp;
            int exp_lock;
            wp = WIN * (rs[ri] + 1);
            exp_lock = (cnts[ci] >= WIN - TOL && cnts[ci] <= WIN + TOL) ? 1 : 0;
            vco_half = half_for(rs[ri], ss[si], cnts[ci]);
            program_ratios(rs[ri], ss[si]);
            cycles(3 * wp / 2);
            chk("R3 sweep one window", int'(lock), 0);
            cycles(wp);
            // R2 window length and divider ratios set the count; R9 band edges
            chk($sformatf("R9 r=%0d s=%0d n=%0d", rs[ri], ss[si], cnts[ci]),
                int'(lock), exp_lock);
          end
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule